// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the device-side answer to an SMBus alert-response poll. It watches already-synchronized SCL and SDA lines at the bit level. When the host reads from the alert response address while this device has an alert outstanding, the block acknowledges the address byte. It then returns its own 7-bit address, most significant bit first, as the upper seven bits of the data byte. The last bit of that byte is sent as 0.

The address is sent through an open-drain pull-down enable, so several alerting devices can drive the bus together. A 0 bit dominates the wired-AND line, which means the device with the numerically lowest address wins. If a bit this device left released is seen low at an SCL rising edge, the device has lost. It stops driving for the rest of the byte, and its alert is not cleared. When the host's acknowledge clock ends a byte that the device won, the block emits a one-cycle cleared pulse. The surrounding logic uses that pulse to drop its alert line.

Top module: `ara_responder`

## Requirements
- R1: After reset the SDA pull-down enable is 0 and the cleared pulse is 0.
- R2: A first byte of 0x19 (7-bit address 0Ch in bits 7:1, read flag 1 in bit 0) with alert_pending high makes the block pull SDA low while SCL is high on the ninth clock.
- R3: Any other first byte, including 0x18 (the same address with the write flag), leaves SDA released for the whole transaction.
- R4: With alert_pending low, the 0x19 byte is not acknowledged and SDA stays released.
- R5: After its acknowledge, the block sends the byte {own_addr, 0}, most significant bit first, over the next eight clocks. It pulls SDA low while SCL is high for each 0 bit and leaves SDA released for each 1 bit.
- R6: If SDA is sampled low at an SCL rising edge during a bit that the block released, the block has lost arbitration. It does not pull SDA for any remaining bit of that byte.
- R7: alert_cleared goes high for exactly one clock, one cycle after the SCL rising edge of the host's acknowledge clock that follows the data byte. This happens only if arbitration was not lost; a lost byte produces no pulse.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. A START, including a repeated START in the middle of a transfer, restarts reception of the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level (wired-AND bus) |
| alert_pending | input | 1 | High while this device has an alert outstanding |
| own_addr | input | ADDR_W | This device's 7-bit bus address |
| sda_pull | output | 1 | Registered enable for the SDA pull-down driver |
| alert_cleared | output | 1 | One-cycle pulse when the alert response is won |

## Verification
On a single SCL rising edge the block counts a transmitted bit and also tests for lost arbitration. A rival device that pulls a 0 against one of this block's released 1 bits therefore provokes both actions in the same cycle. The rival is modelled as a second pull-down on the shared SDA net. Rival addresses are chosen to differ from the block's own address in the first bit, in a late bit, or in the block's favour. The scoreboard judges every later bit of that byte as released, and it expects no cleared pulse when the block loses. A repeated START issued while the first data bit is already staged checks that restarting address reception takes priority over the transmit path.

// File: rtl/ara_pkg.sv
package ara_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_DONE
  } ara_state_t;
endpackage

// File: rtl/ara_bus_cond.sv
module ara_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/ara_addr_rx.sv
module ara_addr_rx #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  input  logic scl_rise,
  input  logic sda,
  output logic byte_done,
  output logic ara_hit
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic [ADDR_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (enable && scl_rise) begin
      shreg <= {shreg[ADDR_W-2:0], sda};
      cnt   <= cnt + 1'b1;
    end
  end

  assign byte_done = enable && scl_rise && (cnt == CNT_W'(BYTE_W - 1));
  assign ara_hit   = ({shreg, sda} == {ARA_ADDR, 1'b1});
endmodule

// File: rtl/ara_fsm.sv
module ara_fsm
  import ara_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda,
  input  logic              byte_done,
  input  logic              ara_hit,
  input  logic              alert_pending,
  input  logic [ADDR_W-1:0] own_addr,
  output ara_state_t        state,
  output logic              sda_pull,
  output logic              alert_cleared
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] tx;
  logic [CNT_W-1:0]  bcnt;
  logic              lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      sda_pull      <= 1'b0;
      alert_cleared <= 1'b0;
      lost          <= 1'b0;
      bcnt          <= '0;
      tx            <= '0;
    end else begin
      alert_cleared <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        sda_pull <= 1'b0;
        lost     <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (byte_done) begin
              state <= (ara_hit && alert_pending) ? ST_ACK : ST_DONE;
              tx    <= {own_addr, 1'b0};
              bcnt  <= '0;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!sda_pull) begin
                sda_pull <= 1'b1;
              end else begin
                sda_pull <= ~tx[BYTE_W-1];
                state    <= ST_SEND;
              end
            end
          end
          ST_SEND: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
              if (!sda_pull && !sda) lost <= 1'b1;
            end else if (scl_fall) begin
              if (bcnt == CNT_W'(BYTE_W)) begin
                sda_pull <= 1'b0;
                state    <= ST_MACK;
              end else begin
                tx       <= tx << 1;
                sda_pull <= ~lost & ~tx[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              alert_cleared <= ~lost;
              state         <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_pull);
  assert_pending_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && byte_done && !alert_pending && !start_det && !stop_det)
      |=> (state == ST_DONE));
  assert_lost_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    lost |-> !sda_pull);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    alert_cleared |=> !alert_cleared);
  assert_pulse_won_R7: assert property (@(posedge clk) disable iff (rst)
    alert_cleared |-> !lost);
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_pull));
endmodule

// File: rtl/ara_responder.sv
module ara_responder
  import ara_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              alert_pending,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              sda_pull,
  output logic              alert_cleared
);
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       byte_done, ara_hit;
  ara_state_t state;

  ara_bus_cond i_cond (
    .clk(clk), .rst(rst), .scl(scl_in), .sda(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ara_addr_rx #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) i_rx (
    .clk(clk), .rst(rst), .clear(start_det),
    .enable(state == ST_ADDR), .scl_rise(scl_rise), .sda(sda_in),
    .byte_done(byte_done), .ara_hit(ara_hit)
  );

  ara_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda(sda_in),
    .byte_done(byte_done), .ara_hit(ara_hit),
    .alert_pending(alert_pending), .own_addr(own_addr),
    .state(state), .sda_pull(sda_pull), .alert_cleared(alert_cleared)
  );

  assert_start_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> (state == ST_ADDR && !sda_pull));
endmodule

// File: tb/test_ara_responder.sv
module test_ara_responder;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string tag;
    bit    exp;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       r_pull = 1'b0;
  logic       alert_pending = 1'b0;
  logic [6:0] own_addr = 7'h5A;
  logic       sda_pull;
  logic       alert_cleared;
  wire        sda_bus = m_sda & ~sda_pull & ~r_pull;

  int   checks = 0;
  int   errors = 0;
  int   pulses = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ara_responder i_ara_responder (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
    .alert_pending(alert_pending), .own_addr(own_addr),
    .sda_pull(sda_pull), .alert_cleared(alert_cleared)
  );

  always @(posedge clk) if (!rst && alert_cleared) pulses++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: sample the pull-down in the middle of each SCL high phase
  always begin
    @(posedge scl);
    repeat (2) @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, sda_pull, e.exp);
    end
  end

  task automatic clk_bit(input bit m, input bit rv, input bit exp, input string tag);
    q.push_back('{tag, exp});
    m_sda  = m;
    r_pull = rv;
    repeat (4) @(negedge clk);
    scl = 1'b1;
    repeat (4) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic do_start();
    m_sda  = 1'b1;
    r_pull = 1'b0;
    repeat (2) @(negedge clk);
    scl = 1'b1;
    repeat (4) @(negedge clk);
    m_sda = 1'b0;
    repeat (4) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic do_stop();
    m_sda  = 1'b0;
    r_pull = 1'b0;
    repeat (2) @(negedge clk);
    scl = 1'b1;
    repeat (4) @(negedge clk);
    m_sda = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 released after stop", sda_pull, 0);
  endtask

  task automatic send_addr(input bit [7:0] abyte, input bit alert, output bit resp);
    alert_pending = alert;
    for (int i = 7; i >= 0; i--) clk_bit(abyte[i], 1'b0, 1'b0, "R3 quiet during address");
    resp = (abyte == 8'h19) && alert;
    if (resp)                 clk_bit(1'b1, 1'b0, 1'b1, "R2 ack of alert response");
    else if (abyte == 8'h19)  clk_bit(1'b1, 1'b0, 1'b0, "R4 no ack without alert");
    else                      clk_bit(1'b1, 1'b0, 1'b0, "R3 no ack for other byte");
  endtask

  task automatic read_data(input bit rival_on, input bit [6:0] rival, output bit won);
    bit [7:0] dutb;
    bit [7:0] rvb;
    bit       lost;
    bit       rlost;
    dutb  = {own_addr, 1'b0};
    rvb   = {rival, 1'b0};
    lost  = 1'b0;
    rlost = !rival_on;
    for (int i = 7; i >= 0; i--) begin
      bit dp, rp, bus;
      dp  = !lost && !dutb[i];
      rp  = !rlost && !rvb[i];
      clk_bit(1'b1, rp, dp, lost ? "R6 silent after loss" : "R5 address bit");
      bus = !(dp || rp);
      if (!lost && !dp && !bus) lost = 1'b1;
      if (!rlost && !rp && !bus) rlost = 1'b1;
    end
    clk_bit(1'b1, 1'b0, 1'b0, "R7 released in host ack clock");
    won = !lost;
  endtask

  task automatic full_txn(input bit [7:0] abyte, input bit alert,
                          input bit rival_on, input bit [6:0] rival);
    int p0;
    bit resp, won;
    p0  = pulses;
    won = 1'b0;
    do_start();
    send_addr(abyte, alert, resp);
    if (resp) read_data(rival_on, rival, won);
    else for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, 1'b0, "R3 quiet for rest");
    do_stop();
    check("R7 cleared pulse count", pulses - p0, int'(won));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    bit resp, won;
    repeat (3) @(negedge clk);
    check("R1 pull after reset", sda_pull, 0);
    check("R1 pulse after reset", alert_cleared, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    own_addr = 7'h5A;
    full_txn(8'h19, 1'b1, 1'b0, 7'h00);   // R2 R5 R7 plain win
    full_txn(8'h19, 1'b0, 1'b0, 7'h00);   // R4
    full_txn(8'h18, 1'b1, 1'b0, 7'h00);   // R3 write flag
    full_txn(8'h33, 1'b1, 1'b0, 7'h00);   // R3 foreign address
    full_txn(8'h19, 1'b1, 1'b1, 7'h2A);   // R6 lose on first bit
    full_txn(8'h19, 1'b1, 1'b1, 7'h5B);   // R6 rival loses, block wins
    full_txn(8'h19, 1'b1, 1'b1, 7'h58);   // R6 lose on a late bit
    own_addr = 7'h00;
    full_txn(8'h19, 1'b1, 1'b0, 7'h00);   // R5 all zero
    own_addr = 7'h7F;
    full_txn(8'h19, 1'b1, 1'b1, 7'h7F);   // R5 all ones, equal rival

    // R8: repeated START right after the acknowledge restarts reception
    own_addr = 7'h5A;
    p0 = pulses;
    do_start();
    send_addr(8'h19, 1'b1, resp);
    do_start();
    send_addr(8'h19, 1'b1, resp);
    read_data(1'b0, 7'h00, won);
    do_stop();
    check("R8 one pulse after repeated start", pulses - p0, 1);

    repeat (4) @(negedge clk);
    check("R8 idle pull", sda_pull, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule